// File: doc/BRIEF.md
# Transitional Timing Sample Compressor

The block samples a vector of input channels on every rising edge of the sample clock while a run is active. It passes an entry to the downstream acquisition memory only around points where an assigned channel changes. Each entry carries a time tag holding the sample index, counted from the start of the run, so the full timing of the waveform can be rebuilt from the sparse record.

The channels are split into equal groups, and each group models one pod pair. Every group decides on its own which samples to keep. Every group has its own write strobe, its own fill count and its own full flag, so a quiet group fills its memory more slowly than a busy one.

A "sample" is the value on `chan_in` at a rising clock edge where `run` is high. Sample k of a run is the k-th such edge, counting from 0. The entry for sample k is presented in the cycle after sample k+1 is taken. For the final sample of a run, it is presented in the cycle after the first edge where `run` is low.

Top module: `xition_capture`

## Requirements
- R1: A change on a channel whose `chan_mask` bit is 0 never causes an entry to be written.
- R2: When a group's masked bits change between sample k-1 and sample k, and the samples around them are steady, that group writes both sample k-1 (the old state) and sample k (the new state).
- R3: When a group's masked bits change on every sample, each sample is written exactly once. No sample is written twice.
- R4: Sample 0 of every run is written for every group, even when the run lasts a single sample.
- R5: `wr_tag` equals the index k of the sample being written. The entry for sample k appears one cycle after sample k+1 is taken, or one cycle after the stop edge for the last sample. When `run` has been low for two edges, no write occurs.
- R6: Groups act independently. `wr_en[g]` and the fill count of group g depend only on channels g*GROUP_W to g*GROUP_W+GROUP_W-1, and that slice of `wr_data` holds the group's channels.
- R7: After DEPTH writes in a group, `full[g]` rises together with the last write. That group then writes nothing more until the next run starts, and `full[g]` stays high while the run continues.
- R8: A rising `run` starts a new run. It clears every full flag and fill count, and it restarts the sample index at 0.
- R9: During and right after reset, `wr_en` and `full` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | High while acquiring |
| chan_in | input | GROUPS*GROUP_W | Channel values |
| chan_mask | input | GROUPS*GROUP_W | 1 marks a channel as assigned |
| wr_en | output | GROUPS | Per-group memory write strobe |
| wr_data | output | GROUPS*GROUP_W | Sample being written |
| wr_tag | output | TAG_W | Sample index of the entry |
| full | output | GROUPS | Per-group memory full |

## Verification
The bench builds the block with two groups of four channels, a depth of 8 and a 12-bit tag. The shallow depth lets a busy group reach full within a few dozen samples while the quiet group keeps writing. Two groups are enough to show independent fill and the per-group slice of the data. Four channels per group allow a mix of assigned and unassigned bits inside one group, which exercises the masking.

// File: rtl/xition_capture.sv
module xition_capture #(
  parameter int GROUPS  = 2,
  parameter int GROUP_W = 4,
  parameter int DEPTH   = 16,
  parameter int TAG_W   = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run,
  input  logic [GROUPS*GROUP_W-1:0]   chan_in,
  input  logic [GROUPS*GROUP_W-1:0]   chan_mask,
  output logic [GROUPS-1:0]           wr_en,
  output logic [GROUPS*GROUP_W-1:0]   wr_data,
  output logic [TAG_W-1:0]            wr_tag,
  output logic [GROUPS-1:0]           full
);
  localparam int N  = GROUPS * GROUP_W;
  localparam int CW = $clog2(DEPTH + 1);

  logic             run_q, have1, first1;
  logic [N-1:0]     d1;
  logic [TAG_W-1:0] cnt, t1;
  logic [GROUPS-1:0] chg1, gdiff, want;

  wire             start = run & ~run_q;
  wire [N-1:0]     diff  = (chan_in ^ d1) & chan_mask;
  wire [TAG_W-1:0] base  = start ? '0 : cnt;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [CW-1:0] fill;
    assign gdiff[g] = |diff[g*GROUP_W +: GROUP_W];
    assign want[g]  = have1 & (first1 | chg1[g] | (run & gdiff[g]));

    always_ff @(posedge clk) begin
      if (rst) begin
        fill     <= '0;
        full[g]  <= 1'b0;
        wr_en[g] <= 1'b0;
        chg1[g]  <= 1'b0;
      end else begin
        wr_en[g] <= want[g] & ~full[g];
        if (run) chg1[g] <= ~start & gdiff[g];
        if (start) begin
          fill    <= '0;
          full[g] <= 1'b0;
        end else if (want[g] && !full[g]) begin
          fill <= fill + 1'b1;
          if (fill + 1'b1 == CW'(DEPTH)) full[g] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      have1   <= 1'b0;
      first1  <= 1'b0;
      d1      <= '0;
      cnt     <= '0;
      t1      <= '0;
      wr_data <= '0;
      wr_tag  <= '0;
    end else begin
      run_q   <= run;
      wr_data <= d1;
      wr_tag  <= t1;
      if (run) begin
        d1     <= chan_in;
        t1     <= base;
        cnt    <= base + 1'b1;
        have1  <= 1'b1;
        first1 <= start;
      end else begin
        have1  <= 1'b0;
        first1 <= 1'b0;
      end
    end
  end
endmodule

module xition_capture_checker #(
  parameter int GROUPS = 2,
  parameter int TAG_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic [GROUPS-1:0] wr_en,
  input logic [TAG_W-1:0]  wr_tag,
  input logic [GROUPS-1:0] full
);
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!run && $past(!run)) |=> (wr_en == '0));

  a_r5_tag_moves: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) |=> (!(|wr_en) || wr_tag != $past(wr_tag)));

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    a_r7_full_with_write: assert property (@(posedge clk) disable iff (rst)
      $rose(full[g]) |-> wr_en[g]);

    a_r7_full_sticky: assert property (@(posedge clk) disable iff (rst)
      (full[g] && run && $past(run)) |=> full[g]);
  end

  a_r9_reset_clean: assert property (@(posedge clk)
    $past(rst) |-> (wr_en == '0 && full == '0));
endmodule

bind xition_capture xition_capture_checker #(.GROUPS(GROUPS), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .wr_en(wr_en), .wr_tag(wr_tag), .full(full)
);

// File: tb/xition_capture_bench.sv
`timescale 1ns/1ps
module xition_capture_bench;
  localparam int G = 2, GW = 4, DEPTH = 8, TW = 12, N = G * GW;

  logic clk = 0, rst = 1, run = 0;
  logic [N-1:0] chan_in = '0, chan_mask = '1;
  logic [G-1:0] wr_en, full;
  logic [N-1:0] wr_data;
  logic [TW-1:0] wr_tag;

  always #2 clk = ~clk;

  xition_capture #(.GROUPS(G), .GROUP_W(GW), .DEPTH(DEPTH), .TAG_W(TW)) u_xition_capture (
    .clk(clk), .rst(rst), .run(run), .chan_in(chan_in), .chan_mask(chan_mask),
    .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag), .full(full)
  );

  int checks = 0, errors = 0;
  string req = "R9";

  logic [N-1:0] hist[$];
  int           fillc[G];
  logic [G-1:0] e_wr = '0, e_full = '0;
  logic [N-1:0] e_data = '0;
  int           e_tag = 0;

  function automatic bit gd(int g, logic [N-1:0] a, logic [N-1:0] b);
    return |(((a ^ b) & chan_mask) >> (g * GW) & {GW{1'b1}});
  endfunction

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic emit(int k, bit last);
    e_data = hist[k];
    e_tag  = k;
    for (int g = 0; g < G; g++) begin
      bit keep = (k == 0) || gd(g, hist[k], hist[k-1]) || (!last && gd(g, hist[k], hist[k+1]));
      if (keep && !e_full[g]) begin
        e_wr[g] = 1'b1;
        fillc[g]++;
        if (fillc[g] == DEPTH) e_full[g] = 1'b1;
      end
    end
  endtask

  task automatic model(bit r, logic [N-1:0] d);
    e_wr = '0;
    if (r) begin
      if (hist.size() == 0) begin
        e_full = '0;
        for (int g = 0; g < G; g++) fillc[g] = 0;
      end
      hist.push_back(d);
      if (hist.size() >= 2) emit(hist.size() - 2, 1'b0);
    end else if (hist.size() > 0) begin
      emit(hist.size() - 1, 1'b1);
      hist.delete();
    end
  endtask

  task automatic step(bit r, logic [N-1:0] d);
    run = r; chan_in = d;
    @(posedge clk);
    model(r, d);
    @(negedge clk);
    chk("wr_en", wr_en, e_wr);
    chk("full", full, e_full);
    for (int g = 0; g < G; g++)
      if (e_wr[g]) chk("wr_data slice", wr_data[g*GW +: GW], e_data[g*GW +: GW]);
    if (|e_wr) chk("wr_tag", wr_tag, e_tag);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    req = "R9";
    chk("reset wr_en", wr_en, 0);
    chk("reset full", full, 0);
    rst = 0;
    step(0, '0); step(0, '0);

    req = "R4";
    step(1, 8'h5A); step(0, 8'h5A); step(0, 8'h5A);

    req = "R2";
    for (int i = 0; i < 24; i++) step(1, (i >= 6 && i < 14) ? 8'h11 : 8'h00);
    step(0, '0); step(0, '0);

    req = "R3";
    for (int i = 0; i < 6; i++) step(1, (i % 2) ? 8'h03 : 8'h00);
    step(0, '0); step(0, '0);

    req = "R1";
    chan_mask = 8'h0F;
    for (int i = 0; i < 20; i++) step(1, {i[0], 3'b000, i[2], 3'b000});
    step(0, '0); step(0, '0);
    chan_mask = '1;

    req = "R6";
    for (int i = 0; i < 20; i++) step(1, {4'h0, i[3:0]} ^ ((i == 10) ? 8'h40 : 8'h00));
    step(0, '0); step(0, '0);

    req = "R7";
    for (int i = 0; i < 30; i++) step(1, {(i > 20) ? 4'hF : 4'h0, 3'b000, i[0]});
    step(0, '0); step(0, '0);

    req = "R8";
    for (int i = 0; i < 30; i++) step(1, {3'b000, i[0], 4'h0});
    step(0, '0); step(0, '0);

    req = "R5";
    for (int i = 0; i < 40; i++) step(1, (i % 7 == 3) ? 8'h81 : 8'h00);
    step(0, '0); step(0, '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule